// File: doc/BRIEF.md
# NAND Prefetch and Write-Posting Engine

This block sits between a host bus and the byte-wide data port of a NAND flash device and decouples the two through a 64-byte byte FIFO. The host opens a transfer by giving a chip-select number, a direction, a byte length and a flag that selects DMA pacing. In read mode the engine pulls bytes from flash into the FIFO ahead of the host. The host then takes them out as 32-bit words. In write mode the host posts 16-bit halfwords into the FIFO and the engine drains them to flash one byte at a time.

The host paces itself with two counts. The FIFO count gives the bytes ready to read in read mode and the free bytes in write mode. The remaining count gives the flash-side bytes still to move. In DMA mode a level request tells a DMA controller that a full 64-byte frame can be serviced. The transfer stays open after the remaining count reaches zero, and a stop command closes it. A new start is refused while a transfer is open.

Top module: `nand_prefetch_engine`

## Requirements
- R1: After reset the engine is idle: `active`, `dmaReq`, both flash strobes and both error pulses are 0, and `fifoCount` and `remainCount` are 0.
- R2: A start request while idle opens a transfer. From the next cycle `active` is 1, `selCs` holds the requested chip select, and `remainCount` equals the requested length. `startWrite` = 0 selects read and 1 selects write.
- R3: A start request while `active` is 1 is refused. `startBusyErr` is 1 in the next cycle, and chip select, direction and remaining count are unchanged.
- R4: In read mode `flashRdStrobe` is high in each cycle in which `flashReady` is 1, the remaining count is nonzero and the FIFO holds fewer than 64 bytes. Each strobe captures `flashRdData` into the FIFO and lowers `remainCount` by one.
- R5: In read mode `fifoCount` gives the bytes held. `hostRdData` presents the next four bytes little-endian, with the oldest byte in bits 7:0. A `hostRdEn` pulse with at least 4 bytes held removes them.
- R6: In write mode `fifoCount` gives 64 minus the bytes held. A `hostWrEn` pulse with at least 2 bytes free stores `hostWrData`, and bits 7:0 go to flash before bits 15:8.
- R7: In write mode `flashWrStrobe` is high in each cycle in which `flashReady` is 1, the remaining count is nonzero and the FIFO holds data. `flashWrData` is the oldest byte, and `remainCount` drops by one per strobe. It therefore reaches zero only after the last byte has gone to flash.
- R8: A host read that is not in read mode or finds fewer than 4 bytes held, and a host write that is not in write mode or finds fewer than 2 bytes free, move no data. `fifoErr` is 1 in the next cycle.
- R9: In read mode with DMA selected, `dmaReq` is high while the FIFO holds 64 bytes, or while the remaining count is zero and bytes are still held. Without DMA selected, `dmaReq` stays 0.
- R10: In write mode with DMA selected, `dmaReq` is high while the FIFO is empty and the host has posted fewer bytes than the transfer length.
- R11: A stop request empties the FIFO and closes the transfer. From the next cycle `active`, `remainCount` and `fifoCount` are 0. A stop in the same cycle as a start wins over the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start-transfer request pulse |
| startCs | input | CS_W | Chip select for the new transfer |
| startWrite | input | 1 | Direction: 0 read, 1 write |
| startDma | input | 1 | Select DMA frame pacing |
| startLen | input | LEN_W | Transfer length in bytes |
| stopReq | input | 1 | Stop and clear the engine |
| active | output | 1 | Transfer open |
| selCs | output | CS_W | Chip select of the open transfer |
| startBusyErr | output | 1 | Start refused (one-cycle pulse) |
| hostRdEn | input | 1 | Host reads one 32-bit word |
| hostRdData | output | 32 | Next four FIFO bytes, oldest in bits 7:0 |
| hostWrEn | input | 1 | Host posts one 16-bit halfword |
| hostWrData | input | 16 | Halfword to post |
| fifoErr | output | 1 | Rejected host access (one-cycle pulse) |
| fifoCount | output | CNT_W | Bytes held (read) or free (write); 0 when idle |
| remainCount | output | LEN_W | Flash-side bytes still to move |
| dmaReq | output | 1 | DMA frame request level |
| flashReady | input | 1 | Flash port can move a byte this cycle |
| flashRdStrobe | output | 1 | Capture flashRdData this cycle |
| flashRdData | input | 8 | Byte from flash |
| flashWrStrobe | output | 1 | flashWrData is written this cycle |
| flashWrData | output | 8 | Byte to flash |

## Verification
The bench fills the FIFO to exactly 64 bytes and then frees one word. It checks that fetching stops at full, and that a single pop unblocks exactly one more fetch in the following cycle. An engine off by one there would overrun its storage or stall for good. Host accesses at each edge are rejected on purpose: a read with an empty FIFO, a write in read mode, and the 33rd halfword into a full write FIFO. A design that let any of these through would corrupt the pointers without raising the error. The remaining count is followed byte by byte during a write drain, because a design that counted host posts instead of flash writes would report zero while data was still in the FIFO. The bench also issues a refused start, and a stop that collides with a start. A busy check in the wrong order would restart a live transfer, and the wrong priority would leave the engine running.

// File: rtl/nand_pf_pkg.sv
package nand_pf_pkg;
  // Strobes from the control to the byte FIFO datapath
  typedef struct packed {
    logic clear;     // drop all contents
    logic pushByte;  // store one byte from flash
    logic pushHalf;  // store two bytes from the host
    logic popByte;   // release one byte to flash
    logic popWord;   // release four bytes to the host
  } fifo_ctl_t;
endpackage

// File: rtl/nand_pf_fifo.sv
module nand_pf_fifo
  import nand_pf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifo_ctl_t        ctl,
  input  logic [7:0]       flashByte,
  input  logic [15:0]      hostHalf,
  output logic [CNT_W-1:0] fill,
  output logic [7:0]       headByte,
  output logic [31:0]      headWord
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr, wrPtrInc;
  logic [2:0]       pushAmt, popAmt;
  logic [PTR_W-1:0] peekIdx [4];

  assign wrPtrInc = wrPtr + PTR_W'(1);

  always_comb begin
    pushAmt = 3'd0;
    if (ctl.pushByte) pushAmt = 3'd1;
    else if (ctl.pushHalf) pushAmt = 3'd2;
    popAmt = 3'd0;
    if (ctl.popByte) popAmt = 3'd1;
    else if (ctl.popWord) popAmt = 3'd4;
  end

  always_ff @(posedge clk) begin
    if (ctl.pushByte) mem[wrPtr] <= flashByte;
    if (ctl.pushHalf) begin
      mem[wrPtr]    <= hostHalf[7:0];
      mem[wrPtrInc] <= hostHalf[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) begin
      rdPtr <= '0;
      wrPtr <= '0;
      fill  <= '0;
    end else begin
      rdPtr <= rdPtr + PTR_W'(popAmt);
      wrPtr <= wrPtr + PTR_W'(pushAmt);
      fill  <= fill + CNT_W'(pushAmt) - CNT_W'(popAmt);
    end
  end

  // Word view of the four oldest bytes, oldest in the low lane
  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign peekIdx[k] = rdPtr + PTR_W'(k);
    assign headWord[8*k +: 8] = mem[peekIdx[k]];
  end

  assign headByte = mem[rdPtr];
endmodule

// File: rtl/nand_pf_ctrl.sv
module nand_pf_ctrl
  import nand_pf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LEN_W = 16,
  parameter int CS_W  = 3,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CS_W-1:0]  startCs,
  input  logic             startWrite,
  input  logic             startDma,
  input  logic [LEN_W-1:0] startLen,
  input  logic             stopReq,
  input  logic             hostRdEn,
  input  logic             hostWrEn,
  input  logic             flashReady,
  input  logic [CNT_W-1:0] fill,
  output fifo_ctl_t        ctl,
  output logic             active,
  output logic [CS_W-1:0]  selCs,
  output logic             startBusyErr,
  output logic             fifoErr,
  output logic [CNT_W-1:0] fifoCount,
  output logic [LEN_W-1:0] remainCount,
  output logic             dmaReq,
  output logic             flashRdStrobe,
  output logic             flashWrStrobe
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic             activeQ, dirWriteQ, dmaQ, busyErrQ, fifoErrQ;
  logic [CS_W-1:0]  csQ;
  logic [LEN_W-1:0] remainQ, hostLeftQ;
  logic [CNT_W-1:0] freeBytes;
  logic startTake, startRefuse, remainNz, rdMove, wrMove;
  logic hostRdOk, hostWrOk, hostBad;

  assign freeBytes   = FULL - fill;
  assign startTake   = startReq & ~activeQ & ~stopReq;
  assign startRefuse = startReq & activeQ & ~stopReq;
  assign remainNz    = (remainQ != '0);

  assign rdMove   = activeQ & ~dirWriteQ & flashReady & remainNz & (fill != FULL);
  assign wrMove   = activeQ & dirWriteQ & flashReady & remainNz & (fill != '0);
  assign hostRdOk = hostRdEn & activeQ & ~dirWriteQ & (fill >= CNT_W'(4));
  assign hostWrOk = hostWrEn & activeQ & dirWriteQ & (freeBytes >= CNT_W'(2));
  assign hostBad  = (hostRdEn & ~hostRdOk) | (hostWrEn & ~hostWrOk);

  always_comb begin
    ctl.clear    = stopReq | startTake;
    ctl.pushByte = rdMove & ~stopReq;
    ctl.pushHalf = hostWrOk & ~stopReq;
    ctl.popByte  = wrMove & ~stopReq;
    ctl.popWord  = hostRdOk & ~stopReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ   <= 1'b0;
      dirWriteQ <= 1'b0;
      dmaQ      <= 1'b0;
      csQ       <= '0;
      remainQ   <= '0;
      hostLeftQ <= '0;
      busyErrQ  <= 1'b0;
      fifoErrQ  <= 1'b0;
    end else begin
      busyErrQ <= startRefuse;
      fifoErrQ <= hostBad & ~stopReq;
      if (stopReq) begin
        activeQ   <= 1'b0;
        remainQ   <= '0;
        hostLeftQ <= '0;
      end else if (startTake) begin
        activeQ   <= 1'b1;
        dirWriteQ <= startWrite;
        dmaQ      <= startDma;
        csQ       <= startCs;
        remainQ   <= startLen;
        hostLeftQ <= startLen;
      end else begin
        if (rdMove || wrMove) remainQ <= remainQ - LEN_W'(1);
        if (hostWrOk)
          hostLeftQ <= (hostLeftQ >= LEN_W'(2)) ? hostLeftQ - LEN_W'(2) : '0;
      end
    end
  end

  assign active        = activeQ;
  assign selCs         = csQ;
  assign startBusyErr  = busyErrQ;
  assign fifoErr       = fifoErrQ;
  assign remainCount   = remainQ;
  assign flashRdStrobe = rdMove;
  assign flashWrStrobe = wrMove;
  assign fifoCount     = !activeQ ? '0 : (dirWriteQ ? freeBytes : fill);
  assign dmaReq = activeQ & dmaQ &
                  (dirWriteQ ? ((fill == '0) & (hostLeftQ != '0))
                             : ((fill == FULL) | (~remainNz & (fill != '0))));
endmodule

// File: rtl/nand_prefetch_engine.sv
module nand_prefetch_engine
  import nand_pf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LEN_W = 16,
  parameter int CS_W  = 3,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CS_W-1:0]  startCs,
  input  logic             startWrite,
  input  logic             startDma,
  input  logic [LEN_W-1:0] startLen,
  input  logic             stopReq,
  output logic             active,
  output logic [CS_W-1:0]  selCs,
  output logic             startBusyErr,
  input  logic             hostRdEn,
  output logic [31:0]      hostRdData,
  input  logic             hostWrEn,
  input  logic [15:0]      hostWrData,
  output logic             fifoErr,
  output logic [CNT_W-1:0] fifoCount,
  output logic [LEN_W-1:0] remainCount,
  output logic             dmaReq,
  input  logic             flashReady,
  output logic             flashRdStrobe,
  input  logic [7:0]       flashRdData,
  output logic             flashWrStrobe,
  output logic [7:0]       flashWrData
);
  fifo_ctl_t        fifoCtl;
  logic [CNT_W-1:0] fill;

  nand_pf_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CS_W(CS_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .startReq(startReq), .startCs(startCs), .startWrite(startWrite),
    .startDma(startDma), .startLen(startLen), .stopReq(stopReq),
    .hostRdEn(hostRdEn), .hostWrEn(hostWrEn), .flashReady(flashReady),
    .fill(fill), .ctl(fifoCtl),
    .active(active), .selCs(selCs), .startBusyErr(startBusyErr),
    .fifoErr(fifoErr), .fifoCount(fifoCount), .remainCount(remainCount),
    .dmaReq(dmaReq), .flashRdStrobe(flashRdStrobe), .flashWrStrobe(flashWrStrobe)
  );

  nand_pf_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rstN(rstN), .ctl(fifoCtl),
    .flashByte(flashRdData), .hostHalf(hostWrData),
    .fill(fill), .headByte(flashWrData), .headWord(hostRdData)
  );
endmodule

// File: rtl/nand_pf_checker.sv
module nand_pf_checker #(
  parameter int DEPTH = 64,
  parameter int LEN_W = 16,
  parameter int CS_W  = 3,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             startReq,
  input logic             stopReq,
  input logic             active,
  input logic [CS_W-1:0]  selCs,
  input logic             startBusyErr,
  input logic [CNT_W-1:0] fifoCount,
  input logic [LEN_W-1:0] remainCount,
  input logic             dmaReq,
  input logic             flashReady,
  input logic             flashRdStrobe,
  input logic             flashWrStrobe
);
  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    active && startReq && !stopReq |=> startBusyErr && active && $stable(selCs));

  assert_stop_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !active && remainCount == '0 && fifoCount == '0);

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH));

  assert_strobe_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    (flashRdStrobe || flashWrStrobe) |-> active && flashReady && remainCount != '0
      && !(flashRdStrobe && flashWrStrobe));

  assert_rd_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    flashRdStrobe && !stopReq |=> remainCount == $past(remainCount) - LEN_W'(1));

  assert_wr_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    flashWrStrobe && !stopReq |=> remainCount == $past(remainCount) - LEN_W'(1));

  assert_no_regrow_R7: assert property (@(posedge clk) disable iff (!rstN)
    active && !stopReq |=> remainCount <= $past(remainCount));

  assert_dma_active_R9: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> active);
endmodule

bind nand_prefetch_engine nand_pf_checker #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CS_W(CS_W))
  u_checker (.*);

// File: tb/tb_nand_prefetch_engine.sv
`timescale 1ns/1ps
module tb_nand_prefetch_engine;
  localparam int DEPTH = 64;
  localparam int LEN_W = 16;
  localparam int CS_W  = 3;
  localparam int CNT_W = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 0, startWrite = 0, startDma = 0, stopReq = 0;
  logic [CS_W-1:0] startCs = '0;
  logic [LEN_W-1:0] startLen = '0;
  logic hostRdEn = 0, hostWrEn = 0, flashReady = 0;
  logic [15:0] hostWrData = '0;
  logic active, startBusyErr, fifoErr, dmaReq, flashRdStrobe, flashWrStrobe;
  logic [CS_W-1:0] selCs;
  logic [31:0] hostRdData;
  logic [CNT_W-1:0] fifoCount;
  logic [LEN_W-1:0] remainCount;
  logic [7:0] flashRdData, flashWrData;

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  int rdIdx = 0;
  int wrCnt = 0;
  logic [7:0] wrLog [256];

  always #2.5 clk = ~clk;

  nand_prefetch_engine #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CS_W(CS_W)) dut (.*);

  // Flash model: the byte pattern follows the fetch index; writes are logged
  assign flashRdData = 8'hA0 ^ rdIdx[7:0];
  always @(posedge clk) begin
    if (flashRdStrobe) rdIdx <= rdIdx + 1;
    if (flashWrStrobe) begin
      wrLog[wrCnt[7:0]] <= flashWrData;
      wrCnt <= wrCnt + 1;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic checkEq(input string tag, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startXfer(input logic wr, input logic dma, input logic [CS_W-1:0] cs,
                           input logic [LEN_W-1:0] len);
    startReq = 1; startWrite = wr; startDma = dma; startCs = cs; startLen = len;
    step(1);
    startReq = 0;
  endtask

  task automatic stopXfer();
    stopReq = 1;
    step(1);
    stopReq = 0;
  endtask

  function automatic logic [7:0] expByte(input int base, input int i);
    return 8'hA0 ^ 8'(base + i);
  endfunction

  task automatic testReset();
    checkEq("R1", "active", active, 0);
    checkEq("R1", "fifoCount", fifoCount, 0);
    checkEq("R1", "remainCount", remainCount, 0);
    checkEq("R1", "dmaReq", dmaReq, 0);
    checkEq("R1", "strobes", {flashRdStrobe, flashWrStrobe, startBusyErr, fifoErr}, 0);
  endtask

  task automatic testReadBasic();
    int base;
    flashReady = 1;
    base = rdIdx;
    startXfer(0, 0, 3'd5, 16'd8);
    checkEq("R2", "active", active, 1);
    checkEq("R2", "selCs", selCs, 5);
    checkEq("R2", "remainCount", remainCount, 8);
    step(8);
    checkEq("R4", "remain after fetch", remainCount, 0);
    checkEq("R5", "fifoCount held", fifoCount, 8);
    checkEq("R9", "no dma request without dma", dmaReq, 0);
    checkEq("R5", "word0", hostRdData,
            {expByte(base,3), expByte(base,2), expByte(base,1), expByte(base,0)});
    hostRdEn = 1; step(1); hostRdEn = 0;
    checkEq("R5", "fifoCount after pop", fifoCount, 4);
    checkEq("R5", "word1", hostRdData,
            {expByte(base,7), expByte(base,6), expByte(base,5), expByte(base,4)});
    hostRdEn = 1; step(1); hostRdEn = 0;
    checkEq("R5", "fifoCount empty", fifoCount, 0);
    stopXfer();
  endtask

  task automatic testReadStall();
    flashReady = 0;
    startXfer(0, 0, 3'd1, 16'd100);
    step(3);
    checkEq("R4", "no fetch when not ready", remainCount, 100);
    checkEq("R4", "rd strobe low", flashRdStrobe, 0);
    // refused start leaves the transfer alone
    startXfer(1, 0, 3'd2, 16'd5);
    checkEq("R3", "busy error", startBusyErr, 1);
    checkEq("R3", "selCs kept", selCs, 1);
    checkEq("R3", "remain kept", remainCount, 100);
    checkEq("R3", "read mode kept", fifoCount, 0);
    // underflow and wrong-mode write
    hostRdEn = 1; step(1); hostRdEn = 0;
    checkEq("R8", "underflow flag", fifoErr, 1);
    checkEq("R8", "fifoCount after underflow", fifoCount, 0);
    hostWrEn = 1; hostWrData = 16'hBEEF; step(1); hostWrEn = 0;
    checkEq("R8", "write in read mode flag", fifoErr, 1);
    checkEq("R8", "nothing stored", fifoCount, 0);
    step(1);
    checkEq("R8", "flag is a pulse", fifoErr, 0);
    flashReady = 1;
    step(70);
    checkEq("R4", "fill stops at full", fifoCount, 64);
    checkEq("R4", "remain at full", remainCount, 36);
    checkEq("R4", "no strobe when full", flashRdStrobe, 0);
    hostRdEn = 1; step(1); hostRdEn = 0;
    checkEq("R5", "pop from full", fifoCount, 60);
    step(1);
    checkEq("R4", "fetch resumes", fifoCount, 61);
    checkEq("R4", "remain resumes", remainCount, 35);
    stopXfer();
    flashReady = 0;
  endtask

  task automatic testWriteBasic();
    int base;
    base = wrCnt;
    startXfer(1, 0, 3'd6, 16'd4);
    checkEq("R6", "free at start", fifoCount, 64);
    checkEq("R7", "remain at start", remainCount, 4);
    hostWrEn = 1; hostWrData = 16'h2211; step(1);
    hostWrData = 16'h4433; step(1); hostWrEn = 0;
    checkEq("R6", "free after posts", fifoCount, 60);
    checkEq("R7", "no drain while not ready", remainCount, 4);
    flashReady = 1;
    step(3);
    checkEq("R7", "remain before last byte", remainCount, 1);
    checkEq("R7", "one byte still held", fifoCount, 63);
    step(1);
    checkEq("R7", "remain flushed", remainCount, 0);
    checkEq("R7", "fifo drained", fifoCount, 64);
    checkEq("R6", "byte order", {wrLog[8'(base)], wrLog[8'(base+1)], wrLog[8'(base+2)], wrLog[8'(base+3)]},
            32'h11223344);
    checkEq("R7", "byte count", wrCnt - base, 4);
    stopXfer();
    flashReady = 0;
  endtask

  task automatic testOverflow();
    startXfer(1, 0, 3'd0, 16'd200);
    for (int i = 0; i < 32; i++) begin
      hostWrEn = 1; hostWrData = 16'(i); step(1);
    end
    hostWrEn = 0;
    checkEq("R6", "free when full", fifoCount, 0);
    checkEq("R8", "no error on last fitting post", fifoErr, 0);
    hostWrEn = 1; step(1); hostWrEn = 0;
    checkEq("R8", "overflow flag", fifoErr, 1);
    checkEq("R8", "free after overflow", fifoCount, 0);
    hostRdEn = 1; step(1); hostRdEn = 0;
    checkEq("R8", "read in write mode flag", fifoErr, 1);
    checkEq("R8", "nothing removed", fifoCount, 0);
    stopXfer();
  endtask

  task automatic testStop();
    startXfer(1, 0, 3'd4, 16'd10);
    hostWrEn = 1; hostWrData = 16'h1234; step(1); hostWrEn = 0;
    stopXfer();
    checkEq("R11", "inactive", active, 0);
    checkEq("R11", "remain cleared", remainCount, 0);
    checkEq("R11", "fifoCount cleared", fifoCount, 0);
    stopReq = 1; startReq = 1; startWrite = 0; startLen = 16'd9; step(1);
    stopReq = 0; startReq = 0;
    checkEq("R11", "stop beats start", active, 0);
    checkEq("R11", "remain after collision", remainCount, 0);
  endtask

  task automatic testDmaRead();
    flashReady = 1;
    startXfer(0, 1, 3'd2, 16'd64);
    step(10);
    checkEq("R9", "no request before frame", dmaReq, 0);
    step(54);
    checkEq("R9", "frame full", fifoCount, 64);
    checkEq("R9", "request on full frame", dmaReq, 1);
    hostRdEn = 1; step(1); hostRdEn = 0;
    checkEq("R9", "request held for tail", dmaReq, 1);
    stopXfer();
    flashReady = 0;
  endtask

  task automatic testDmaWrite();
    startXfer(1, 1, 3'd7, 16'd128);
    checkEq("R10", "request when empty", dmaReq, 1);
    hostWrEn = 1; hostWrData = 16'h5566; step(1); hostWrEn = 0;
    checkEq("R10", "request drops with data held", dmaReq, 0);
    flashReady = 1;
    step(2);
    checkEq("R10", "request returns after drain", dmaReq, 1);
    checkEq("R7", "remain after drain", remainCount, 126);
    flashReady = 0;
    stopXfer();
    checkEq("R10", "no request when idle", dmaReq, 0);
  endtask

  initial begin
    step(3);
    rstN = 1;
    step(1);
    testReset();
    testReadBasic();
    testReadStall();
    testWriteBasic();
    testOverflow();
    testStop();
    testDmaRead();
    testDmaWrite();
    step(2);
    summary();
    $finish;
  end
endmodule